// File: doc/BRIEF.md
# Programmable Bit Pattern Sequencer

This block plays four pattern words out onto four serial outputs in lockstep. Each output owns one pattern word. Every rising edge seen on the step input moves all four outputs on by one bit, starting at bit 0 and climbing toward the top bit. A sequence-length input decides how many low-order bits make up one pass. A repeat input decides how many passes are played, and a repeat value of zero means the sequencer never stops.

The step input is sampled in the system clock domain, and only a low-to-high change advances the sequencer. An index output tells which bit position is on the outputs now. A run flag is high while further steps are still accepted. When the last pass ends, the run flag drops and the outputs keep the final bits until the next reset. An active-high synchronous reset restarts the sequencer from any state.

Typical use is a slow stimulus or control-pattern source. A timer or software-written pulse drives the step input, and the four outputs drive enables, selects or test lines.

Top module: `bitseq_top`

## Requirements
- R1: While `rst` is high at a clock edge, `q_o`, `bit_idx_o` and `running_o` are all cleared at that edge. At the first edge after release, `running_o` rises if the clamped length is nonzero.
- R2: The first accepted step after reset puts bit 0 of pattern word c on `q_o[c]` and sets `bit_idx_o` to 0, at the clock edge where the rising step edge is sampled.
- R3: Each further accepted step presents the next higher bit on every lane. A step input held high for several clocks advances by one bit only, and `q_o` and `bit_idx_o` do not change on cycles without a rising step edge.
- R4: One pass consists of the clamped length L of bits, 0 to L-1. The step after bit L-1 presents bit 0 again when more passes remain.
- R5: With `rep_i` = N > 0, exactly N·L steps are accepted. `running_o` falls at the edge that takes the last step. Later steps are ignored: `q_o` keeps the bits of position L-1 and `bit_idx_o` stays at L-1 until reset.
- R6: With `rep_i` = 0, passes repeat without end and `running_o` stays high.
- R7: A `seq_len_i` value above PAT_W acts as PAT_W. A value of 0 keeps the sequencer idle: `running_o` is low, steps are ignored, and `q_o` and `bit_idx_o` stay 0.
- R8: A reset in the middle of a run restarts the sequencer, so that the next step presents bit 0 again with a fresh repeat count.
- R9: All lanes advance together, and lane c always shows the same bit position of its own pattern word, taken from `pat_i[c]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_i | input | NCH*PAT_W | Pattern words; lane c is `pat_i[c]` |
| step_i | input | 1 | Step level; a rising edge advances one bit |
| seq_len_i | input | $clog2(PAT_W)+1 | Bits per pass, clamped to 1..PAT_W; 0 means idle |
| rep_i | input | REP_W | Number of passes; 0 means endless |
| q_o | output | NCH | Current bit of each lane (registered) |
| bit_idx_o | output | $clog2(PAT_W) | Bit position now presented (registered) |
| running_o | output | 1 | High while steps are still accepted (registered) |

## Verification
The bench builds the block with 8-bit patterns, four lanes and a 3-bit repeat field, so the length input reaches 0 to 15. That lets every length value (idle, each legal length, and every value needing the clamp) be crossed with every repeat count from endless to 7. Each step's outputs are checked against the pattern bit selected by (step−1) mod L. The bench also checks the cycle where the run flag falls, the frozen outputs after completion, a step held high for several clocks, and a reset in the middle of a run.

// File: rtl/bitseq_pkg.sv
package bitseq_pkg;

  // Effective pass length: 0 stays 0 (idle), anything above lim is cut to lim.
  function automatic int unsigned clamp_len(input int unsigned req, input int unsigned lim);
    if (req == 0) return 0;
    if (req > lim) return lim;
    return req;
  endfunction

endpackage

// File: rtl/bitseq_edge.sv
module bitseq_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/bitseq_ctrl.sv
module bitseq_ctrl #(
  parameter int PAT_W = 32,
  parameter int REP_W = 8,
  localparam int IDX_W = $clog2(PAT_W),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [REP_W-1:0] rep_i,
  output logic             take_o,
  output logic [IDX_W-1:0] pos_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             running_o
);
  import bitseq_pkg::*;

  localparam int RW1 = REP_W + 1;

  logic [LEN_W-1:0] eff_len;
  logic [IDX_W-1:0] pos_q;
  logic [REP_W-1:0] reps_q;
  logic             done_q;
  logic             last_bit, last_rep, live, done_nxt;

  always_comb begin
    eff_len  = LEN_W'(clamp_len(32'(len_i), PAT_W));
    live     = (eff_len != '0) && !done_q;
    take_o   = adv_i && live;
    last_bit = (LEN_W'(pos_q) >= (eff_len - LEN_W'(1)));
    last_rep = (rep_i != '0) && ((RW1'(reps_q) + RW1'(1)) == RW1'(rep_i));
    done_nxt = done_q | (take_o & last_bit & last_rep);
  end

  assign pos_o = pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= '0;
      reps_q    <= '0;
      done_q    <= 1'b0;
      idx_o     <= '0;
      running_o <= 1'b0;
    end else begin
      running_o <= (eff_len != '0) && !done_nxt;
      if (take_o) begin
        idx_o <= pos_q;
        if (last_bit) begin
          pos_q <= '0;
          if (last_rep)           done_q <= 1'b1;
          else if (rep_i != '0)   reps_q <= reps_q + REP_W'(1);
        end else begin
          pos_q <= pos_q + IDX_W'(1);
        end
      end
    end
  end

  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> (done_q && !running_o));

  // R7
  idle_len_chk: assert property (@(posedge clk) disable iff (rst)
    (len_i == '0) |=> !running_o);

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (take_o && last_bit) |=> (pos_q == '0));

endmodule

// File: rtl/bitseq_lane.sv
module bitseq_lane #(
  parameter int PAT_W = 32,
  localparam int IDX_W = $clog2(PAT_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PAT_W-1:0] pat_i,
  input  logic [IDX_W-1:0] sel_i,
  input  logic             load_i,
  output logic             q_o
);

  always_ff @(posedge clk) begin
    if (rst)         q_o <= 1'b0;
    else if (load_i) q_o <= pat_i[sel_i];
  end

endmodule

// File: rtl/bitseq_top.sv
module bitseq_top #(
  parameter int NCH   = 4,
  parameter int PAT_W = 32,
  parameter int REP_W = 8,
  localparam int IDX_W = $clog2(PAT_W),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NCH-1:0][PAT_W-1:0]  pat_i,
  input  logic                       step_i,
  input  logic [LEN_W-1:0]           seq_len_i,
  input  logic [REP_W-1:0]           rep_i,
  output logic [NCH-1:0]             q_o,
  output logic [IDX_W-1:0]           bit_idx_o,
  output logic                       running_o
);

  logic             step_rise;
  logic             take;
  logic [IDX_W-1:0] pos;

  bitseq_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (step_i),
    .rise_o (step_rise)
  );

  bitseq_ctrl #(.PAT_W(PAT_W), .REP_W(REP_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .adv_i     (step_rise),
    .len_i     (seq_len_i),
    .rep_i     (rep_i),
    .take_o    (take),
    .pos_o     (pos),
    .idx_o     (bit_idx_o),
    .running_o (running_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    bitseq_lane #(.PAT_W(PAT_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .pat_i  (pat_i[c]),
      .sel_i  (pos),
      .load_i (take),
      .q_o    (q_o[c])
    );
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (q_o == '0 && bit_idx_o == '0 && !running_o));

  // R3
  hold_without_step_chk: assert property (@(posedge clk) disable iff (rst)
    !step_rise |=> ($stable(q_o) && $stable(bit_idx_o)));

  // R3
  single_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && $past(step_i)) |=> $stable(bit_idx_o));

endmodule

// File: tb/bitseq_top_tb_top.sv
module bitseq_top_tb_top;
  localparam int NCH   = 4;
  localparam int PAT_W = 8;
  localparam int REP_W = 3;
  localparam int IDX_W = $clog2(PAT_W);
  localparam int LEN_W = IDX_W + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0][PAT_W-1:0] pat = '0;
  logic step = 1'b0;
  logic [LEN_W-1:0] seq_len = '0;
  logic [REP_W-1:0] rep = '0;
  logic [NCH-1:0] q;
  logic [IDX_W-1:0] bit_idx;
  logic running;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  bitseq_top #(.NCH(NCH), .PAT_W(PAT_W), .REP_W(REP_W)) dut_i (
    .clk(clk), .rst(rst), .pat_i(pat), .step_i(step),
    .seq_len_i(seq_len), .rep_i(rep),
    .q_o(q), .bit_idx_o(bit_idx), .running_o(running)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] exp_bits(input int k);
    logic [NCH-1:0] v;
    for (int c = 0; c < NCH; c++) v[c] = pat[c][k];
    return v;
  endfunction

  // Reset held over one edge, outputs checked, then released.
  task automatic do_reset(input int eff);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(q == '0, "R1 q after reset", int'(q), 0);
    chk(bit_idx == '0, "R1 idx after reset", int'(bit_idx), 0);
    chk(!running, "R1 run during reset", int'(running), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(running == (eff != 0), "R1 run after release", int'(running), int'(eff != 0));
  endtask

  // One rising edge on the step input; outputs sampled at the negedge after it.
  task automatic do_step();
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // Sweep every length value against every repeat count.
    for (int len = 0; len < (1 << LEN_W); len++) begin
      for (int r = 0; r < (1 << REP_W); r++) begin
        int eff;
        int total;
        eff = (len == 0) ? 0 : ((len > PAT_W) ? PAT_W : len);
        seq_len = LEN_W'(len);
        rep = REP_W'(r);
        for (int c = 0; c < NCH; c++) pat[c] = PAT_W'($urandom);
        do_reset(eff);
        if (eff == 0) begin
          for (int s = 0; s < 3; s++) begin
            do_step();
            chk(q == '0 && bit_idx == '0, "R7 idle ignores steps", int'(q), 0);
            chk(!running, "R7 idle run low", int'(running), 0);
          end
        end else begin
          total = (r == 0) ? 3 * eff + 2 : r * eff;
          for (int n = 1; n <= total; n++) begin
            int k;
            bit exp_run;
            k = (n - 1) % eff;
            do_step();
            if (n == 1)
              chk(q == exp_bits(0), "R2 R9 first bit", int'(q), int'(exp_bits(0)));
            else if (k == 0)
              chk(q == exp_bits(0), "R4 R9 wrap to bit 0", int'(q), int'(exp_bits(0)));
            else if (len > PAT_W)
              chk(q == exp_bits(k), "R7 R9 clamped length", int'(q), int'(exp_bits(k)));
            else
              chk(q == exp_bits(k), "R3 R9 next bit", int'(q), int'(exp_bits(k)));
            chk(int'(bit_idx) == k, "R3 R4 bit index", int'(bit_idx), k);
            exp_run = !((r != 0) && (n == total));
            if (r == 0)
              chk(running == exp_run, "R6 endless run", int'(running), int'(exp_run));
            else
              chk(running == exp_run, "R5 run flag", int'(running), int'(exp_run));
          end
          if (r != 0) begin
            for (int s = 0; s < 2; s++) begin
              do_step();
              chk(q == exp_bits(eff - 1), "R5 last bits held", int'(q), int'(exp_bits(eff - 1)));
              chk(int'(bit_idx) == eff - 1, "R5 index held", int'(bit_idx), eff - 1);
              chk(!running, "R5 stays stopped", int'(running), 0);
            end
          end
        end
      end
    end

    // Held-high step advances once only.
    seq_len = LEN_W'(PAT_W);
    rep = '0;
    pat[0] = 8'b1010_0110;
    pat[1] = 8'b0101_1001;
    pat[2] = 8'b1111_0000;
    pat[3] = 8'b0000_1111;
    do_reset(PAT_W);
    do_step();
    step = 1'b1;
    repeat (4) @(negedge clk);
    chk(int'(bit_idx) == 1, "R3 held step single advance", int'(bit_idx), 1);
    chk(q == exp_bits(1), "R3 held step bits", int'(q), int'(exp_bits(1)));
    step = 1'b0;
    @(negedge clk);

    // Reset in the middle of a limited run.
    rep = REP_W'(1);
    do_reset(PAT_W);
    for (int s = 0; s < 5; s++) do_step();
    chk(int'(bit_idx) == 4, "R8 before mid-run reset", int'(bit_idx), 4);
    do_reset(PAT_W);
    do_step();
    chk(int'(bit_idx) == 0 && q == exp_bits(0), "R8 restart at bit 0", int'(bit_idx), 0);
    for (int s = 1; s < PAT_W; s++) do_step();
    chk(!running, "R8 fresh repeat count", int'(running), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule